// File: doc/BRIEF.md
# Periodic Check Schedule Generator

This block tells every processing element of a one-directional linear array, cycle by cycle, whether its current task should be run under concurrent error checking or run plain. Each element owns a phase counter modulo a period `PERIOD`. The element checks during the first `DUTY` phases of every period and computes unchecked during the remaining `PERIOD - DUTY` phases. The checking cost is therefore reduced to the fraction `DUTY / PERIOD` of the cycles.

The counters do not all start in the same place. Element `i` starts at phase `(DUTY * i) mod PERIOD`. Each element therefore runs `DUTY` phases ahead of its upstream neighbour, and a band of checked slots sweeps from the output end of the array back toward the input end over time. An error that is created in an unchecked slot and carried downstream is then met by a checking element within a bounded number of cycles.

The counters move only on cycles where the shared advance strobe is high. The array control can therefore stall the schedule together with the computation. The block also flags the last `ceil((PERIOD-DUTY)/DUTY)` elements as end elements. An error that reaches one of them can leave the array before any check catches it.

Top module: `pace_sched`

## Requirements
- R1: One clock edge with `rst` high puts element `i` at phase `(DUTY*i) mod PERIOD`, visible on `phase_o` right after that edge.
- R2: `chk_en_o[i]` is 1 exactly when element `i`'s phase is below `DUTY`. Phases are 0 to `PERIOD-1`, with `1 <= DUTY < PERIOD`.
- R3: On an edge with `adv_i` high and `rst` low, every phase increases by one, and `PERIOD-1` wraps to 0.
- R4: On an edge with `adv_i` low and `rst` low, every phase and every enable bit keeps its value.
- R5: At all times after reset, the phase of element `i+1` equals (phase of element `i` + `DUTY`) mod `PERIOD`.
- R6: Over any `PERIOD` consecutive advances, each element is enabled on exactly `DUTY` of them. With `PERIOD=5` and `DUTY=2`, element 0's enable reads 1,1,0,0,0 from reset.
- R7: `end_pe_o[i]` is 1 exactly when `i >= NUM_PE - ceil((PERIOD-DUTY)/DUTY)`.
- R8: When `rst` and `adv_i` are both high on an edge, the reset load wins and no advance happens.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; loads the start phases |
| adv_i | input | 1 | Advance strobe; all counters step by one when high |
| chk_en_o | output | NUM_PE | Per-element check enable, registered |
| phase_o | output | NUM_PE*PW | Packed phase indices; element `i` sits at bits `[i*PW +: PW]`, where PW = clog2(PERIOD) |
| end_pe_o | output | NUM_PE | Marks the elements whose errors may escape the array unchecked |

## Verification
The two functions that can fall in the same cycle are the reset load and the advance step: both write every phase counter on the same edge. The bench holds the advance strobe high across a reset in the middle of a run. It then expects the start phases, not the start phases plus one, and after release it expects exactly one step per high strobe. The wrap from `PERIOD-1` to 0 meets the upstream skew relation on the same edge in every element. The bench therefore checks the neighbour relation and an arithmetic model `(t + DUTY*i) mod PERIOD` after each of many consecutive steps, including stretches where the strobe toggles.

// File: rtl/pace_pkg.sv
package pace_pkg;

  // Integer ceiling division for positive operands.
  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  // Bits needed to hold a phase index 0..period-1.
  function automatic int phase_bits(input int period);
    return (period > 1) ? $clog2(period) : 1;
  endfunction

  // Start phase of element idx: skewed by duty per element.
  function automatic int start_phase(input int period, input int duty, input int idx);
    return (duty * idx) % period;
  endfunction

endpackage

// File: rtl/pace_phase_ctr.sv
module pace_phase_ctr
  import pace_pkg::*;
#(
  parameter int PERIOD = 5,
  parameter int DUTY   = 2,
  parameter int OFFSET = 0,
  localparam int PW    = phase_bits(PERIOD)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv_i,
  output logic [PW-1:0] phase_o,
  output logic          chk_o
);

  localparam logic [PW-1:0] LAST   = PW'(PERIOD - 1);
  localparam logic [PW-1:0] START  = PW'(OFFSET);
  localparam logic [PW-1:0] DUTY_P = PW'(DUTY);
  localparam logic          START_CHK = (OFFSET < DUTY);

  logic [PW-1:0] phase_q;
  logic [PW-1:0] phase_nxt;
  logic          chk_q;

  always_comb begin
    if (phase_q == LAST) phase_nxt = '0;
    else                 phase_nxt = phase_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= START;
      chk_q   <= START_CHK;
    end else if (adv_i) begin
      phase_q <= phase_nxt;
      chk_q   <= (phase_nxt < DUTY_P);
    end
  end

  assign phase_o = phase_q;
  assign chk_o   = chk_q;

  // R2: phase stays inside the period
  assert_phase_range_R2: assert property (@(posedge clk) disable iff (rst)
    phase_q <= LAST)
    else $error("phase out of range");

  // R2: enable register tracks the checked window
  assert_window_R2: assert property (@(posedge clk) disable iff (rst)
    chk_q == (phase_q < DUTY_P))
    else $error("enable does not match phase window");

  // R3: one step per strobe, wrapping at the period end
  assert_step_R3: assert property (@(posedge clk) disable iff (rst)
    adv_i |=> (phase_q == (($past(phase_q) == LAST) ? '0 : $past(phase_q) + 1'b1)))
    else $error("phase did not step");

  // R4: no strobe, no movement
  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !adv_i |=> ($stable(phase_q) && $stable(chk_q)))
    else $error("phase moved without strobe");

  // R8: reset load wins over the strobe
  assert_reset_wins_R8: assert property (@(posedge clk)
    rst |=> (phase_q == START && chk_q == START_CHK))
    else $error("reset did not load start phase");

endmodule

// File: rtl/pace_end_map.sv
module pace_end_map
  import pace_pkg::*;
#(
  parameter int PERIOD = 5,
  parameter int DUTY   = 2,
  parameter int NUM_PE = 7
) (
  output logic [NUM_PE-1:0] end_o
);

  // Worst-case cycles an error may travel before a check meets it.
  localparam int MAX_LAT   = ceil_div(PERIOD - DUTY, DUTY);
  localparam int FIRST_END = NUM_PE - MAX_LAT;

  for (genvar g = 0; g < NUM_PE; g++) begin : g_end
    assign end_o[g] = (g >= FIRST_END);
  end

endmodule

// File: rtl/pace_sched.sv
module pace_sched
  import pace_pkg::*;
#(
  parameter int PERIOD = 5,
  parameter int DUTY   = 2,
  parameter int NUM_PE = 7,
  localparam int PW    = phase_bits(PERIOD)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 adv_i,
  output logic [NUM_PE-1:0]    chk_en_o,
  output logic [NUM_PE*PW-1:0] phase_o,
  output logic [NUM_PE-1:0]    end_pe_o
);

  logic [PW-1:0] ph [NUM_PE];

  for (genvar g = 0; g < NUM_PE; g++) begin : g_pe
    pace_phase_ctr #(
      .PERIOD (PERIOD),
      .DUTY   (DUTY),
      .OFFSET (start_phase(PERIOD, DUTY, g))
    ) ctr_i (
      .clk     (clk),
      .rst     (rst),
      .adv_i   (adv_i),
      .phase_o (ph[g]),
      .chk_o   (chk_en_o[g])
    );
    assign phase_o[g*PW +: PW] = ph[g];
  end

  pace_end_map #(
    .PERIOD (PERIOD),
    .DUTY   (DUTY),
    .NUM_PE (NUM_PE)
  ) end_map_i (
    .end_o (end_pe_o)
  );

  // R5: each element runs DUTY phases ahead of its upstream neighbour
  for (genvar g = 0; g < NUM_PE - 1; g++) begin : g_skew
    assert_skew_R5: assert property (@(posedge clk) disable iff (rst)
      int'(ph[g+1]) == ((int'(ph[g]) + DUTY) % PERIOD))
      else $error("neighbour skew broken");
  end

endmodule

// File: tb/pace_sched_tb_top.sv
`timescale 1ns/1ps
module pace_sched_tb_top;
  localparam int M  = 5;
  localparam int N  = 2;
  localparam int V  = 7;
  localparam int PW = 3;
  localparam int LMAX = (M - N + N - 1) / N;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic adv = 1'b0;
  logic [V-1:0]    chk_en;
  logic [V*PW-1:0] phase;
  logic [V-1:0]    end_pe;

  int n_chk = 0;
  int n_bad = 0;
  int t = 0;

  always #2 clk = ~clk;

  pace_sched #(.PERIOD(M), .DUTY(N), .NUM_PE(V)) dut_i (
    .clk      (clk),
    .rst      (rst),
    .adv_i    (adv),
    .chk_en_o (chk_en),
    .phase_o  (phase),
    .end_pe_o (end_pe)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int ph_of(input int i);
    return int'(phase[i*PW +: PW]);
  endfunction

  task automatic verify(input string tag);
    for (int i = 0; i < V; i++) begin
      int e;
      e = (t + N * i) % M;
      check(ph_of(i) == e, tag, ph_of(i), e);
      check(chk_en[i] == (e < N), "R2 enable", int'(chk_en[i]), int'(e < N));
      if (i < V - 1)
        check(ph_of(i+1) == (ph_of(i) + N) % M, "R5 skew", ph_of(i+1), (ph_of(i) + N) % M);
    end
  endtask

  task automatic step(input bit a);
    @(negedge clk);
    adv = a;
    @(posedge clk);
    if (a) t++;
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int ones [V];
    logic [4:0] seq0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t = 0;
    verify("R1 reset phase");

    for (int i = 0; i < V; i++)
      check(end_pe[i] == (i >= V - LMAX), "R7 end flag", int'(end_pe[i]), int'(i >= V - LMAX));

    // R6: first period, sequence of element 0 and per-element counts
    for (int i = 0; i < V; i++) ones[i] = 0;
    seq0 = '0;
    for (int k = 0; k < M; k++) begin
      seq0[4-k] = chk_en[0];
      for (int i = 0; i < V; i++) ones[i] += int'(chk_en[i]);
      step(1'b1);
      verify("R3 advance");
    end
    check(seq0 == 5'b11000, "R6 sequence", int'(seq0), 24);
    for (int i = 0; i < V; i++)
      check(ones[i] == N, "R6 count", ones[i], N);

    // R3: several full periods with continuous strobe, crossing the wrap
    for (int k = 0; k < 3 * M; k++) begin
      step(1'b1);
      verify("R3 wrap");
    end

    // R4: strobe with gaps
    for (int k = 0; k < 24; k++) begin
      step((k % 3) != 1);
      verify("R4 hold");
    end

    // R8: reset asserted while strobe is high
    @(negedge clk);
    rst = 1'b1;
    adv = 1'b1;
    @(posedge clk);
    #1;
    t = 0;
    verify("R8 reset over strobe");
    @(posedge clk);
    #1;
    verify("R8 reset held");
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    t = 1;
    #1;
    verify("R8 first step after release");
    for (int k = 0; k < 2 * M; k++) begin
      step(1'b1);
      verify("R3 after reset");
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule